// File: doc/BRIEF.md
# Static RAM Cycle Sequencer

This block drives a level-controlled static RAM with its address, write data, data-drive enable, active-low chip select and active-high write enable. It paces each memory cycle by counting controller clock cycles. Every interval the memory demands is a nanosecond parameter, turned into clock cycles by rounding up against the clock period. Those intervals are address setup, write pulse width, write recovery, data setup, data hold, chip-select setup, access time, read cycle time, write cycle time and read-modify-write cycle time.

The host offers an operation code, an address, a data word and a modify mode while `idle` is high. It gets back a one-cycle `done` pulse with `rdata` valid. Three cycle types exist. A read holds the memory selected for the access window and then samples it. A write runs setup, pulse and recovery phases. A read-modify-write reads the location, computes a new word from the word it read, and writes that word back to the same address without releasing chip select. Between cycles the memory is deselected, write enable is low and the data bus is not driven.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset and whenever `idle` is high, `mem_cs_n` is 1, `mem_we` is 0, `mem_d_oe` is 0, and `done` is 0 outside the cycle that ends an operation.
- R2: `mem_we` is high only while `mem_cs_n` is low. `mem_addr` does not change while `mem_cs_n` stays low. A write stores `req_wdata`, and its `rdata` reports that same word.
- R3: Write enable rises no sooner than S cycles after chip select falls, where S = max(1, ceil(AS), ceil(CSS) − P). A plain write waits exactly S cycles. A read-modify-write waits exactly Racc + S cycles, where Racc = max(1, ceil(ACC)).
- R4: Each write pulse lasts exactly P = max(1, ceil(WP), ceil(DS)) cycles, and never as long as ceil(WPMAX) cycles.
- R5: `mem_d_oe` is high for the whole write pulse and for exactly ceil(DH) cycles after write enable falls. `mem_d` is stable whenever it is driven.
- R6: A write cycle keeps chip select low for exactly S + P + W cycles, where W = max(1, ceil(WR), ceil(DH), ceil(WC) − S − P).
- R7: A read keeps chip select low, with write enable low, for exactly max(1, ceil(ACC), ceil(RC)) cycles. `rdata` is the memory word sampled in the last of those cycles.
- R8: A read-modify-write returns the old word on `rdata` and writes back a new word chosen by `req_mod`. Bits where the `req_wdata` mask is 0 keep their old value. Masked bits follow the mode: 00 keep, 01 set to 1, 10 clear to 0, 11 invert.
- R9: `req_op` codes are 00 read, 01 write, 10 read-modify-write, and 11 read.
- R10: `done` is high for exactly one cycle, the cycle in which chip select returns high. A request presented while `idle` is low has no effect.
- R11: A read-modify-write keeps chip select low for exactly Racc + S + P + max(W, ceil(RMW) − Racc − S − P) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 2 | Operation code |
| req_mod | input | 2 | Modify mode for read-modify-write |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word, or the bit mask for read-modify-write |
| idle | output | 1 | Controller can take a request |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdata | output | DW | Word read (or word written) |
| mem_addr | output | AW | Memory address |
| mem_d | output | DW | Memory write data |
| mem_d_oe | output | 1 | Drive enable for the write data bus |
| mem_q | input | DW | Memory read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we | output | 1 | Memory write enable, active high |

## Verification
The properties assume `rst` is asserted from time zero for at least one clock edge. They also assume the parameters give a write pulse shorter than the maximum. They place no constraint on request timing, because requests that arrive while busy must be ignored anyway. The bench drives requests only between clock edges and holds each for one cycle, including one request made on purpose during a busy write. Its memory model returns corrupted data until the address has been held for the access time, and it stores an inverted word if write enable is high while the data bus is not driven.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RMW   = 2'b10,
    OP_READ2 = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    MOD_KEEP  = 2'b00,
    MOD_SET   = 2'b01,
    MOD_CLEAR = 2'b10,
    MOD_FLIP  = 2'b11
  } mod_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_SETUP,
    PH_PULSE,
    PH_RECOV
  } phase_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int pulse_len(int wp_ns, int ds_ns, int clk_ns);
    return imax(1, imax(ns2cyc(wp_ns, clk_ns), ns2cyc(ds_ns, clk_ns)));
  endfunction

  function automatic int setup_len(int as_ns, int css_ns, int wp_ns, int ds_ns, int clk_ns);
    return imax(1, imax(ns2cyc(as_ns, clk_ns),
                        ns2cyc(css_ns, clk_ns) - pulse_len(wp_ns, ds_ns, clk_ns)));
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_nxt,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_comb begin
    if (load)          cnt_nxt = load_val;
    else if (cnt == '0) cnt_nxt = '0;
    else               cnt_nxt = cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/sram_word_modify.sv
module sram_word_modify
  import sram_ctl_pkg::*;
#(
  parameter int DW = 1
) (
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] mask,
  input  logic [1:0]    mode,
  output logic [DW-1:0] new_word
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      if (!mask[i]) new_word[i] = old_word[i];
      else begin
        case (mode)
          MOD_SET:   new_word[i] = 1'b1;
          MOD_CLEAR: new_word[i] = 1'b0;
          MOD_FLIP:  new_word[i] = ~old_word[i];
          default:   new_word[i] = old_word[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 1,
  parameter int CLK_NS     = 8,
  parameter int T_AS_NS    = 110,
  parameter int T_WP_NS    = 370,
  parameter int T_WPMAX_NS = 10000,
  parameter int T_WR_NS    = 100,
  parameter int T_DS_NS    = 250,
  parameter int T_DH_NS    = 100,
  parameter int T_CSS_NS   = 370,
  parameter int T_ACC_NS   = 580,
  parameter int T_RC_NS    = 580,
  parameter int T_WC_NS    = 580,
  parameter int T_RMW_NS   = 1050
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_mod,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_d,
  output logic          mem_d_oe,
  input  logic [DW-1:0] mem_q,
  output logic          mem_cs_n,
  output logic          mem_we
);
  localparam int C_DH    = ns2cyc(T_DH_NS, CLK_NS);
  localparam int L_PULSE = pulse_len(T_WP_NS, T_DS_NS, CLK_NS);
  localparam int L_SETUP = setup_len(T_AS_NS, T_CSS_NS, T_WP_NS, T_DS_NS, CLK_NS);
  localparam int L_WREC  = imax(1, imax(imax(ns2cyc(T_WR_NS, CLK_NS), C_DH),
                                        ns2cyc(T_WC_NS, CLK_NS) - L_SETUP - L_PULSE));
  localparam int L_READ  = imax(1, imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS)));
  localparam int L_RMWR  = imax(1, ns2cyc(T_ACC_NS, CLK_NS));
  localparam int L_RREC  = imax(L_WREC, ns2cyc(T_RMW_NS, CLK_NS) - L_RMWR - L_SETUP - L_PULSE);
  localparam int L_MAX   = imax(imax(L_READ, L_RREC), imax(L_PULSE, L_SETUP));
  localparam int CW      = $clog2(L_MAX + 1);

  phase_e        ph, nxt_ph;
  logic          rmw_q;
  logic [1:0]    mod_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] mod_word;
  logic          ld, tmr_zero, oe_nxt;
  logic [CW-1:0] ld_val, tmr_nxt, rec_last;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val),
    .cnt_nxt(tmr_nxt), .zero(tmr_zero)
  );

  sram_word_modify #(.DW(DW)) u_modify (
    .old_word(mem_q), .mask(mask_q), .mode(mod_q), .new_word(mod_word)
  );

  // phase sequencing
  always_comb begin
    nxt_ph = ph;
    ld     = 1'b0;
    ld_val = '0;
    case (ph)
      PH_IDLE: if (req_valid) begin
        ld = 1'b1;
        if (req_op == OP_WRITE) begin
          nxt_ph = PH_SETUP;
          ld_val = CW'(L_SETUP - 1);
        end else begin
          nxt_ph = PH_READ;
          ld_val = (req_op == OP_RMW) ? CW'(L_RMWR - 1) : CW'(L_READ - 1);
        end
      end
      PH_READ: if (tmr_zero) begin
        if (rmw_q) begin
          nxt_ph = PH_SETUP;
          ld     = 1'b1;
          ld_val = CW'(L_SETUP - 1);
        end else begin
          nxt_ph = PH_IDLE;
        end
      end
      PH_SETUP: if (tmr_zero) begin
        nxt_ph = PH_PULSE;
        ld     = 1'b1;
        ld_val = CW'(L_PULSE - 1);
      end
      PH_PULSE: if (tmr_zero) begin
        nxt_ph = PH_RECOV;
        ld     = 1'b1;
        ld_val = rmw_q ? CW'(L_RREC - 1) : CW'(L_WREC - 1);
      end
      PH_RECOV: if (tmr_zero) nxt_ph = PH_IDLE;
      default: nxt_ph = PH_IDLE;
    endcase
  end

  // data bus stays driven for the hold window at the start of recovery
  always_comb begin
    rec_last = rmw_q ? CW'(L_RREC - 1) : CW'(L_WREC - 1);
    oe_nxt   = (nxt_ph == PH_PULSE) ||
               ((nxt_ph == PH_RECOV) && ((int'(rec_last) - int'(tmr_nxt)) < C_DH));
  end

  assign idle = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      rmw_q    <= 1'b0;
      mod_q    <= '0;
      mask_q   <= '0;
      mem_addr <= '0;
      mem_d    <= '0;
      rdata    <= '0;
      mem_cs_n <= 1'b1;
      mem_we   <= 1'b0;
      mem_d_oe <= 1'b0;
      done     <= 1'b0;
    end else begin
      ph       <= nxt_ph;
      mem_cs_n <= (nxt_ph == PH_IDLE);
      mem_we   <= (nxt_ph == PH_PULSE);
      mem_d_oe <= oe_nxt;
      done     <= (ph != PH_IDLE) && (nxt_ph == PH_IDLE);
      if (ph == PH_IDLE && req_valid) begin
        mem_addr <= req_addr;
        rmw_q    <= (req_op == OP_RMW);
        mod_q    <= req_mod;
        mask_q   <= req_wdata;
        if (req_op == OP_WRITE) begin
          mem_d <= req_wdata;
          rdata <= req_wdata;
        end
      end
      if (ph == PH_READ && tmr_zero) begin
        rdata <= mem_q;
        mem_d <= mod_word;
      end
    end
  end
endmodule

// File: rtl/sram_cycle_chk.sv
module sram_cycle_chk
  import sram_ctl_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 1,
  parameter int CLK_NS     = 8,
  parameter int T_AS_NS    = 110,
  parameter int T_WP_NS    = 370,
  parameter int T_WPMAX_NS = 10000,
  parameter int T_DS_NS    = 250,
  parameter int T_CSS_NS   = 370
) (
  input logic          clk,
  input logic          rst,
  input logic          idle,
  input logic          done,
  input logic          cs_n,
  input logic          we,
  input logic          oe,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] d
);
  localparam int S_MIN = setup_len(T_AS_NS, T_CSS_NS, T_WP_NS, T_DS_NS, CLK_NS);
  localparam int P_MIN = pulse_len(T_WP_NS, T_DS_NS, CLK_NS);
  localparam int P_MAX = ns2cyc(T_WPMAX_NS, CLK_NS);

  int cs_cnt, we_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_cnt <= 0;
      we_cnt <= 0;
    end else begin
      cs_cnt <= cs_n ? 0 : cs_cnt + 1;
      we_cnt <= we ? we_cnt + 1 : 0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    idle |-> (cs_n && !we && !oe));
  p_we_selected_r2: assert property (@(posedge clk) disable iff (rst)
    we |-> !cs_n);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> $stable(addr));
  p_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(we) |-> (cs_cnt >= S_MIN));
  p_pulse_min_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(we) |-> (we_cnt >= P_MIN));
  p_pulse_max_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> (we_cnt < P_MAX));
  p_data_driven_r5: assert property (@(posedge clk) disable iff (rst)
    we |-> oe);
  p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (oe && $past(oe)) |-> $stable(d));
  p_done_release_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sram_cycle_ctrl sram_cycle_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_AS_NS(T_AS_NS), .T_WP_NS(T_WP_NS),
  .T_WPMAX_NS(T_WPMAX_NS), .T_DS_NS(T_DS_NS), .T_CSS_NS(T_CSS_NS)
) u_chk (
  .clk(clk), .rst(rst), .idle(idle), .done(done), .cs_n(mem_cs_n),
  .we(mem_we), .oe(mem_d_oe), .addr(mem_addr), .d(mem_d)
);

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
  localparam int AW  = 4;
  localparam int DW  = 2;
  localparam int CLK = 8;
  localparam int NW  = 1 << AW;

  function automatic int up(int ns);
    return (ns + CLK - 1) / CLK;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_ACC   = up(580);
  localparam int E_DH    = up(100);
  localparam int E_PULSE = mx(1, mx(up(370), up(250)));
  localparam int E_SETUP = mx(1, mx(up(110), up(370) - E_PULSE));
  localparam int E_WREC  = mx(1, mx(mx(up(100), E_DH), up(580) - E_SETUP - E_PULSE));
  localparam int E_READ  = mx(1, mx(up(580), up(580)));
  localparam int E_RMWR  = mx(1, E_ACC);
  localparam int E_RREC  = mx(E_WREC, up(1050) - E_RMWR - E_SETUP - E_PULSE);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0, req_mod = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic idle, done, mem_d_oe, mem_cs_n, mem_we;
  logic [DW-1:0] rdata, mem_d, mem_q;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;

  sram_cycle_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_mod(req_mod),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_d(mem_d), .mem_d_oe(mem_d_oe), .mem_q(mem_q),
    .mem_cs_n(mem_cs_n), .mem_we(mem_we)
  );

  // memory model: level write, data corrupt until access time has passed
  logic [DW-1:0] mem [NW];
  int acc_cnt = 0;
  always @(posedge clk) begin
    if (mem_cs_n) acc_cnt <= 0;
    else          acc_cnt <= acc_cnt + 1;
    if (!mem_cs_n && mem_we) mem[mem_addr] <= mem_d_oe ? mem_d : ~mem_d;
  end
  always_comb mem_q = (acc_cnt + 1 >= E_ACC) ? mem[mem_addr] : ~mem[mem_addr];

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle shape monitor
  int cur_op = 0;
  int cyc_len = 0, we_len = 0, post_oe = 0;
  bit p_cs_n = 1, p_we = 0, p_done = 0, trk = 0, oe_all = 0;
  logic [AW-1:0] a0 = '0;
  always @(negedge clk) begin
    if (rst) begin
      p_cs_n = 1; p_we = 0; p_done = 0; trk = 0;
    end else begin
      if (!mem_cs_n) begin
        if (p_cs_n) begin cyc_len = 1; a0 = mem_addr; end
        else begin
          cyc_len++;
          if (mem_addr != a0) chk(0, "R2 address moved", int'(mem_addr), int'(a0));
        end
      end
      if (mem_we && !p_we) begin
        if (cur_op == 2) chk(cyc_len - 1 == E_RMWR + E_SETUP, "R3 rmw setup", cyc_len - 1, E_RMWR + E_SETUP);
        else             chk(cyc_len - 1 == E_SETUP, "R3 write setup", cyc_len - 1, E_SETUP);
        we_len = 1; oe_all = mem_d_oe;
      end else if (mem_we) begin
        we_len++; oe_all = oe_all & mem_d_oe;
      end
      if (!mem_we && p_we) begin
        chk(we_len == E_PULSE, "R4 pulse width", we_len, E_PULSE);
        chk(oe_all, "R5 data driven in pulse", int'(oe_all), 1);
        trk = 1; post_oe = 0;
      end
      if (trk) begin
        if (mem_d_oe) post_oe++;
        else begin
          chk(post_oe == E_DH, "R5 data hold", post_oe, E_DH);
          trk = 0;
        end
      end
      if (mem_cs_n && !p_cs_n) begin
        if (cur_op == 1)
          chk(cyc_len == E_SETUP + E_PULSE + E_WREC, "R6 write length", cyc_len, E_SETUP + E_PULSE + E_WREC);
        else if (cur_op == 2)
          chk(cyc_len == E_RMWR + E_SETUP + E_PULSE + E_RREC, "R11 rmw length", cyc_len,
              E_RMWR + E_SETUP + E_PULSE + E_RREC);
        else
          chk(cyc_len == E_READ, "R7 read length", cyc_len, E_READ);
        chk(done == 1'b1, "R10 done at release", int'(done), 1);
      end
      if (done && p_done) chk(0, "R10 done longer than one cycle", 2, 1);
      if (mem_we && (cur_op == 0 || cur_op == 3)) chk(0, "R7 write enable in read", 1, 0);
      p_cs_n = mem_cs_n; p_we = mem_we; p_done = done;
    end
  end

  task automatic start(input int op, input int md, input int a, input int wd);
    @(negedge clk);
    while (!idle) @(negedge clk);
    cur_op = op;
    req_valid = 1'b1; req_op = 2'(op); req_mod = 2'(md);
    req_addr = AW'(a); req_wdata = DW'(wd);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish();
    while (!done) @(negedge clk);
  endtask

  task automatic run(input int op, input int md, input int a, input int wd,
                     input int exp, input string tag);
    start(op, md, a, wd);
    finish();
    chk(int'(rdata) == exp, tag, int'(rdata), exp);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  logic [DW-1:0] shadow [NW];

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(idle && mem_cs_n && !mem_we && !mem_d_oe && !done, "R1 reset state",
        int'({idle, mem_cs_n, mem_we, mem_d_oe, done}), 5'b11000);

    // R2 write sweep
    for (int a = 0; a < NW; a++) begin
      shadow[a] = DW'(a * 3 + 1);
      run(1, 0, a, int'(shadow[a]), int'(shadow[a]), "R2 write reports word");
    end
    // R7 read sweep
    for (int a = 0; a < NW; a++)
      run(0, 0, a, 0, int'(shadow[a]), "R7 read data");
    // R9 code 11 behaves as read
    for (int a = 0; a < 4; a++)
      run(3, 0, a, 0, int'(shadow[a]), "R9 op 11 read");
    for (int a = 0; a < 4; a++)
      run(0, 0, a, 0, int'(shadow[a]), "R9 op 11 left memory unchanged");

    // R8 exhaustive modify modes and masks
    for (int a = 0; a < NW; a++)
      for (int md = 0; md < 4; md++)
        for (int mk = 0; mk < (1 << DW); mk++) begin
          logic [DW-1:0] o, m, n;
          o = shadow[a]; m = DW'(mk);
          case (md)
            1:       n = o | m;
            2:       n = o & ~m;
            3:       n = o ^ m;
            default: n = o;
          endcase
          run(2, md, a, mk, int'(o), "R8 rmw returns old word");
          shadow[a] = n;
          run(0, 0, a, 0, int'(n), "R8 rmw written word");
        end

    // R10 request while busy is ignored
    start(1, 0, 5, int'(~shadow[5]));
    shadow[5] = ~shadow[5];
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; req_addr = AW'(6); req_wdata = ~shadow[6];
    @(negedge clk);
    req_valid = 1'b0;
    finish();
    run(0, 0, 6, 0, int'(shadow[6]), "R10 busy request ignored");
    run(0, 0, 5, 0, int'(shadow[5]), "R2 write before busy request");
    @(negedge clk);
    chk(idle && mem_cs_n && !mem_d_oe, "R1 idle between cycles",
        int'({idle, mem_cs_n, mem_d_oe}), 3'b110);
    report();
  end
endmodule